// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One channel of a programmable interval timer. It holds a 16-bit down-counter that a separate register front end loads. The timer clock input `tclk_i` is sampled in the system clock domain, and each falling edge of it is one count step. A gate input can pause the count, resume it, or retrigger it. Six counting modes set how the count reloads and what waveform the single output `out_o` produces: an interrupt on terminal count, a retriggerable one-shot, a rate generator, a square wave, and software- or hardware-triggered strobes.

The front end passes in a control strobe with a 3-bit mode code, and a count strobe with a complete 16-bit reload value. The live count and the output level are visible at all times. Byte sequencing, bus access, status read-back and BCD counting belong to the front end or are absent. Counting is binary.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is in mode 2 with `out_o` high and `count_o` = 65536, and it stays idle.
- R2: The mode code selects modes 0 to 5 directly. Code 6 behaves as mode 2 and code 7 behaves as mode 3.
- R3: A control strobe stops the counter and discards any written reload value. The next cycle it drives `out_o` low for code 0 and high for every other code. The count value itself is left unchanged. If a count step falls in the same cycle, that step still applies to the count.
- R4: `count_o` changes only in a cycle where the sampled `tclk_i` goes from 1 to 0. The counter does not start until a complete count has been written while the gate is high. In modes 1 and 5 it also waits for a gate trigger.
- R5: A newly written count does not change `count_o` at once. The first count step after the write loads the effective reload value and does not decrement.
- R6: A reload value of 0 acts as 65536. In mode 3 a reload value of 1 acts as 65537. `count_o` is never 0 and never exceeds 65537.
- R7: In mode 0, writing a count drives `out_o` low the next cycle. At terminal count `out_o` goes high, and the counter reloads and keeps counting.
- R8: In modes 2, 4 and 5, `out_o` goes low when the count reaches 1 and high when it reaches 0. Modes 0, 2 and 3 reload at terminal count. Modes 1, 4 and 5 raise `out_o` there, stop, and hold 65536.
- R9: In mode 3, after each count step, `out_o` is high exactly when the count exceeds half the effective reload value, rounded down.
- R10: In modes 0 and 4, a count written while running restarts the count with the new value on the next step. In modes 2 and 3 it takes effect only at the next terminal count.
- R11: A gate falling edge pauses counting in modes 0, 2, 3 and 4, and has no effect in modes 1 and 5. In modes 2 and 3 it also forces `out_o` high the next cycle.
- R12: A gate rising edge makes modes 1, 2, 3 and 5 reload on the next count step, and starts or resumes counting once a count has been written. In mode 1 it also drives `out_o` low.
- R13: Events in one cycle resolve in this order: count step, then gate edge, then count write, then control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tclk_i | input | 1 | Timer clock level; a 1-to-0 change is one count step |
| gate_i | input | 1 | Gate level |
| ctrl_we_i | input | 1 | Control strobe, one cycle |
| ctrl_mode_i | input | 3 | Mode code for the control strobe |
| cnt_we_i | input | 1 | Count strobe carrying a complete reload value |
| cnt_val_i | input | CNT_W | Reload value |
| count_o | output | CNT_W+1 | Live count (65536 and 65537 are reachable) |
| out_o | output | 1 | Channel output level |

## Verification
A count write and a count step can land in the same cycle. The sharpest case is mode 2 when the step brings the count to terminal count. The bench provokes this directly by putting the count strobe on the falling timer-clock sample that finishes a period. It then expects the reload to use the old value and the period after it to use the new one. The bench also lands a control strobe on a count step and expects the decrement to happen and the counter to stop. A random phase mixes strobes, gate edges and clock steps freely against a bench model that follows the ordering in R13.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    typedef enum logic [2:0] {
        MODE0 = 3'd0,
        MODE1 = 3'd1,
        MODE2 = 3'd2,
        MODE3 = 3'd3,
        MODE4 = 3'd4,
        MODE5 = 3'd5
    } pit_mode_e;

    function automatic pit_mode_e pit_decode(input logic [2:0] code);
        case (code)
            3'd6:    return MODE2;
            3'd7:    return MODE3;
            default: return pit_mode_e'(code);
        endcase
    endfunction

    function automatic logic pit_reloads(input pit_mode_e m);
        return (m == MODE0) || (m == MODE2) || (m == MODE3);
    endfunction

    function automatic logic pit_low_at_one(input pit_mode_e m);
        return (m == MODE2) || (m == MODE4) || (m == MODE5);
    endfunction

    function automatic logic pit_gate_pauses(input pit_mode_e m);
        return !((m == MODE1) || (m == MODE5));
    endfunction

    function automatic logic pit_gate_triggers(input pit_mode_e m);
        return !((m == MODE0) || (m == MODE4));
    endfunction

    function automatic logic pit_periodic(input pit_mode_e m);
        return (m == MODE2) || (m == MODE3);
    endfunction

endpackage

// File: rtl/pit_edge_det.sv
`timescale 1ns/1ps
module pit_edge_det #(
    parameter int           N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] lvl_d;

    always_comb begin
        lvl_d = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= RST_VAL;
        else         lvl_q <= lvl_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise_o[i] = sig_i[i] & ~lvl_q[i];
        assign fall_o[i] = ~sig_i[i] & lvl_q[i];
    end
endmodule

// File: rtl/pit_reload_calc.sv
`timescale 1ns/1ps
module pit_reload_calc
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  pit_mode_e        mode_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W:0]   eff_o,
    output logic [CNT_W:0]   half_o
);
    localparam int CW = CNT_W + 1;
    localparam logic [CNT_W:0] FULL = CW'(1) << CNT_W;

    always_comb begin
        if (reload_i == '0)
            eff_o = FULL;
        else if (mode_i == MODE3 && reload_i == CNT_W'(1))
            eff_o = FULL + CW'(1);
        else
            eff_o = {1'b0, reload_i};
        half_o = eff_o >> 1;
    end
endmodule

// File: rtl/pit_core.sv
`timescale 1ns/1ps
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tclk_fall_i,
    input  logic             gate_rise_i,
    input  logic             gate_fall_i,
    input  logic             gate_i,
    input  logic             ctrl_we_i,
    input  pit_mode_e        ctrl_mode_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    input  logic [CNT_W:0]   eff_i,
    input  logic [CNT_W:0]   half_i,
    output pit_mode_e        mode_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W:0]   count_o,
    output logic             out_o
);
    localparam int CW = CNT_W + 1;
    localparam logic [CNT_W:0] FULL = CW'(1) << CNT_W;

    typedef struct packed {
        pit_mode_e        mode;
        logic [CNT_W-1:0] reload;
        logic [CNT_W:0]   count;
        logic             loaded;
        logic             run;
        logic             pend;
        logic             out;
    } chan_t;

    chan_t st_d, st_q;
    logic [CNT_W:0] dec;

    always_comb begin
        st_d = st_q;
        dec  = st_q.count - CW'(1);

        // count step
        if (st_q.run && tclk_fall_i) begin
            if (st_q.pend) begin
                st_d.pend  = 1'b0;
                st_d.count = eff_i;
            end else begin
                st_d.count = dec;
                if (st_q.mode == MODE3)
                    st_d.out = (dec > half_i);
                if (dec == CW'(1) && pit_low_at_one(st_q.mode))
                    st_d.out = 1'b0;
                if (dec == '0) begin
                    st_d.out = 1'b1;
                    if (pit_reloads(st_q.mode)) begin
                        st_d.count = eff_i;
                    end else begin
                        st_d.run   = 1'b0;
                        st_d.count = FULL;
                    end
                end
            end
        end

        // gate edges
        if (gate_fall_i) begin
            if (pit_gate_pauses(st_q.mode))
                st_d.run = 1'b0;
            if (pit_periodic(st_q.mode))
                st_d.out = 1'b1;
        end else if (gate_rise_i) begin
            if (pit_gate_triggers(st_q.mode)) begin
                st_d.pend = 1'b1;
                if (st_q.mode == MODE1)
                    st_d.out = 1'b0;
            end
            st_d.run = st_q.loaded;
        end

        // count write
        if (cnt_we_i) begin
            st_d.reload = cnt_val_i;
            st_d.loaded = 1'b1;
            case (st_q.mode)
                MODE0: begin
                    st_d.out  = 1'b0;
                    st_d.pend = 1'b1;
                    st_d.run  = gate_i;
                end
                MODE4: begin
                    st_d.pend = 1'b1;
                    st_d.run  = gate_i;
                end
                MODE2, MODE3: begin
                    if (!st_d.run) begin
                        st_d.pend = 1'b1;
                        st_d.run  = gate_i;
                    end
                end
                default: ;
            endcase
        end

        // control write
        if (ctrl_we_i) begin
            st_d.mode   = ctrl_mode_i;
            st_d.out    = (ctrl_mode_i != MODE0);
            st_d.reload = '0;
            st_d.loaded = 1'b0;
            st_d.run    = 1'b0;
            st_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode   <= MODE2;
            st_q.reload <= '0;
            st_q.count  <= FULL;
            st_q.loaded <= 1'b0;
            st_q.run    <= 1'b0;
            st_q.pend   <= 1'b0;
            st_q.out    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign out_o    = st_q.out;
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tclk_i,
    input  logic             gate_i,
    input  logic             ctrl_we_i,
    input  logic [2:0]       ctrl_mode_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    output logic [CNT_W:0]   count_o,
    output logic             out_o
);
    localparam int NSIG = 2;
    localparam int TCLK_BIT = 0;
    localparam int GATE_BIT = 1;

    logic [NSIG-1:0] edge_lvl, edge_rise, edge_fall;
    pit_mode_e       cur_mode, wr_mode;
    logic [CNT_W-1:0] reload;
    logic [CNT_W:0]  eff, half;
    logic            tclk_lvl, gate_lvl;

    always_comb begin
        wr_mode = pit_decode(ctrl_mode_i);
    end

    pit_edge_det #(
        .N      (NSIG),
        .RST_VAL(2'b10)
    ) edge_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sig_i ({gate_i, tclk_i}),
        .lvl_q (edge_lvl),
        .rise_o(edge_rise),
        .fall_o(edge_fall)
    );

    assign tclk_lvl = edge_lvl[TCLK_BIT];
    assign gate_lvl = edge_lvl[GATE_BIT];

    pit_reload_calc #(.CNT_W(CNT_W)) calc_i (
        .mode_i  (cur_mode),
        .reload_i(reload),
        .eff_o   (eff),
        .half_o  (half)
    );

    pit_core #(.CNT_W(CNT_W)) core_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tclk_fall_i(edge_fall[TCLK_BIT]),
        .gate_rise_i(edge_rise[GATE_BIT]),
        .gate_fall_i(edge_fall[GATE_BIT]),
        .gate_i     (gate_i),
        .ctrl_we_i  (ctrl_we_i),
        .ctrl_mode_i(wr_mode),
        .cnt_we_i   (cnt_we_i),
        .cnt_val_i  (cnt_val_i),
        .eff_i      (eff),
        .half_i     (half),
        .mode_o     (cur_mode),
        .reload_o   (reload),
        .count_o    (count_o),
        .out_o      (out_o)
    );
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tclk_i,
    input logic             gate_i,
    input logic             ctrl_we_i,
    input logic [2:0]       ctrl_mode_i,
    input logic             cnt_we_i,
    input logic [CNT_W:0]   count_o,
    input logic             out_o,
    input logic [2:0]       mode_q,
    input logic             tclk_q,
    input logic             gate_q
);
    localparam int CW = CNT_W + 1;
    localparam logic [CNT_W:0] TOP = (CW'(1) << CNT_W) + CW'(1);

    assert_count_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != '0) && (count_o <= TOP));

    assert_count_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tclk_q && !tclk_i) |=> $stable(count_o));

    assert_ctrl_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_we_i |=> (out_o == ($past(ctrl_mode_i) != 3'd0)));

    assert_mode0_write_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_we_i && !ctrl_we_i && mode_q == 3'd0) |=> !out_o);

    assert_rate_low_at_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(out_o) && mode_q == 3'd2) |-> (count_o == CW'(1)));

    assert_gate_fall_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_q && !gate_i && !ctrl_we_i && (mode_q == 3'd2 || mode_q == 3'd3)) |=> out_o);
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tclk_i     (tclk_i),
    .gate_i     (gate_i),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_mode_i(ctrl_mode_i),
    .cnt_we_i   (cnt_we_i),
    .count_o    (count_o),
    .out_o      (out_o),
    .mode_q     (cur_mode),
    .tclk_q     (tclk_lvl),
    .gate_q     (gate_lvl)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
    localparam int CNT_W = 16;
    localparam int FULL  = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk = 1'b0;
    logic        gate = 1'b1;
    logic        cw = 1'b0;
    logic [2:0]  code = 3'd0;
    logic        nw = 1'b0;
    logic [15:0] val = 16'd0;
    logic [16:0] count;
    logic        out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pit_channel #(.CNT_W(CNT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .gate_i(gate),
        .ctrl_we_i(cw), .ctrl_mode_i(code), .cnt_we_i(nw), .cnt_val_i(val),
        .count_o(count), .out_o(out)
    );

    // bench model of the requirements, stepped on each clock
    int m_mode, m_reload, m_count;
    bit m_loaded, m_run, m_pend, m_out, m_tq, m_gq;

    function automatic int eff_of(int md, int rl);
        if (rl == 0) return FULL;
        if (md == 3 && rl == 1) return FULL + 1;
        return rl;
    endfunction

    always @(posedge clk) begin
        bit tf, gr, gf;
        int e, c;
        if (!rst_n) begin
            m_mode = 2; m_reload = 0; m_count = FULL; m_loaded = 0;
            m_run = 0; m_pend = 0; m_out = 1; m_tq = 0; m_gq = 1;
        end else begin
            tf = m_tq && !tclk;
            gr = gate && !m_gq;
            gf = !gate && m_gq;
            e  = eff_of(m_mode, m_reload);
            if (m_run && tf) begin
                if (m_pend) begin
                    m_pend = 0; m_count = e;
                end else begin
                    c = m_count - 1;
                    m_count = c;
                    if (m_mode == 3) m_out = (c > e / 2);
                    if (c == 1 && (m_mode == 2 || m_mode == 4 || m_mode == 5)) m_out = 0;
                    if (c == 0) begin
                        m_out = 1;
                        if (m_mode == 0 || m_mode == 2 || m_mode == 3) m_count = e;
                        else begin m_run = 0; m_count = FULL; end
                    end
                end
            end
            if (gf) begin
                if (m_mode != 1 && m_mode != 5) m_run = 0;
                if (m_mode == 2 || m_mode == 3) m_out = 1;
            end else if (gr) begin
                if (m_mode != 0 && m_mode != 4) begin
                    m_pend = 1;
                    if (m_mode == 1) m_out = 0;
                end
                m_run = m_loaded;
            end
            if (nw) begin
                m_reload = val; m_loaded = 1;
                if (m_mode == 0) begin m_out = 0; m_pend = 1; m_run = gate; end
                else if (m_mode == 4) begin m_pend = 1; m_run = gate; end
                else if ((m_mode == 2 || m_mode == 3) && !m_run) begin m_pend = 1; m_run = gate; end
            end
            if (cw) begin
                m_mode = (code == 3'd6) ? 2 : (code == 3'd7) ? 3 : int'(code);
                m_out = (m_mode != 0); m_reload = 0; m_loaded = 0; m_run = 0; m_pend = 0;
            end
            m_tq = tclk; m_gq = gate;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit tc, input bit c_we, input logic [2:0] c_code,
                        input bit n_we, input logic [15:0] n_val);
        @(negedge clk);
        tclk = tc; cw = c_we; code = c_code; nw = n_we; val = n_val;
        @(posedge clk);
        #1;
        cw = 1'b0; nw = 1'b0;
    endtask

    task automatic ctrl(input logic [2:0] c); step(tclk, 1, c, 0, 0); endtask
    task automatic wr(input logic [15:0] v); step(tclk, 0, 0, 1, v); endtask
    task automatic tick(); step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0); endtask
    task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask
    task automatic set_gate(input bit g);
        @(negedge clk); gate = g; @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 out", out, 1); chk("R1 count", count, FULL);
        tick(); chk("R1 idle", count, FULL);

        // R2 code 6 acts as mode 2; R5 deferred load
        ctrl(3'd6); wr(16'd5);
        chk("R5 no change on write", count, FULL);
        tick(); chk("R5 load", count, 5);
        ticks(3); chk("R8 count 2", count, 2); chk("R8 out high", out, 1);
        tick(); chk("R8 low at 1", out, 0);
        tick(); chk("R2 R8 reload", count, 5); chk("R8 high at 0", out, 1);

        // R3 R7 mode 0
        ctrl(3'd0); chk("R3 mode0 low", out, 0);
        wr(16'd3); tick(); chk("R7 load", count, 3); chk("R7 out low", out, 0);
        ticks(2); chk("R7 still low", out, 0);
        tick(); chk("R7 tc high", out, 1); chk("R7 reload", count, 3);

        // R9 square wave
        ctrl(3'd3); wr(16'd4); tick(); chk("R9 load", count, 4);
        tick(); chk("R9 3 high", out, 1);
        tick(); chk("R9 2 low", out, 0);
        tick(); chk("R9 1 low", out, 0);
        tick(); chk("R9 wrap high", out, 1); chk("R9 wrap count", count, 4);

        // R6 effective values, R2 code 7
        ctrl(3'd7); wr(16'd1); tick(); chk("R6 R2 mode3 one", count, FULL + 1);
        ctrl(3'd2); wr(16'd0); tick(); chk("R6 zero", count, FULL);
        tick(); chk("R6 zero dec", count, FULL - 1);

        // R8 mode 4 stops
        ctrl(3'd4); chk("R3 mode4 high", out, 1);
        wr(16'd3); ticks(3); chk("R8 m4 low", out, 0);
        tick(); chk("R8 m4 high", out, 1); chk("R8 m4 stop", count, FULL);
        tick(); chk("R8 m4 stays", count, FULL);

        // R11 R12 gate in mode 2
        ctrl(3'd2); wr(16'd3); ticks(3); chk("R11 pre low", out, 0);
        set_gate(0); chk("R11 forced high", out, 1);
        tick(); chk("R11 paused", count, 1);
        set_gate(1); tick(); chk("R12 reload", count, 3);

        // mode 1 one-shot
        ctrl(3'd1); wr(16'd4); tick(); chk("R4 m1 waits", count, 3);
        set_gate(0); set_gate(1); chk("R12 m1 low", out, 0);
        tick(); chk("R12 m1 load", count, 4);
        set_gate(0); tick(); chk("R11 m1 no pause", count, 3);
        set_gate(1); tick(); chk("R12 retrigger", count, 4);
        ticks(3); chk("R8 m1 still low", out, 0);
        tick(); chk("R8 m1 high", out, 1); chk("R8 m1 stop", count, FULL);

        // R10 new count while running
        ctrl(3'd2); wr(16'd5); ticks(2); wr(16'd2);
        chk("R10 m2 no restart", count, 4);
        ticks(4); chk("R10 m2 new at tc", count, 2);
        ctrl(3'd4); wr(16'd5); ticks(2); wr(16'd9); tick();
        chk("R10 m4 restart", count, 9);

        // R13 count write on terminal step
        ctrl(3'd2); wr(16'd3); ticks(3);
        step(1, 0, 0, 0, 0); step(0, 0, 0, 1, 16'd7);
        chk("R13 old reload", count, 3); chk("R13 out", out, 1);
        ticks(3); chk("R13 new reload", count, 7);
        // R13 control write on a step
        step(1, 0, 0, 0, 0); step(0, 1, 3'd0, 0, 0);
        chk("R13 step applied", count, 6); chk("R3 ctrl out", out, 0);
        tick(); chk("R3 stopped", count, 6);

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            bit r_cw, r_nw;
            r_cw = ($urandom_range(99) < 2);
            r_nw = ($urandom_range(99) < 5);
            if ($urandom_range(99) < 3) gate = ~gate;
            step($urandom_range(1), r_cw, 3'($urandom_range(7)), r_nw,
                 16'($urandom_range(12)));
            chk("R13 random count", count, m_count);
            chk("R13 random out", out, m_out);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule